// File: doc/BRIEF.md
# Two-Cycle Command Capture Decoder

This block sits at the command input of a lookup engine. A master controller sends it commands on a 9-bit bus. A command-valid strobe qualifies the bus, and the block runs on the double-rate clock. Every command takes two consecutive clock cycles. An active-low phase input marks the first of the two, so the block can find the boundary between commands without counting.

The block keeps the opcode and the seven parameter bits from the first cycle. It then checks that the second cycle repeats the same opcode. If it does, the block adds the second cycle's seven parameter bits and produces one registered 16-bit command word, a one-hot operation decode and a one-cycle valid pulse. The four operations are read, write, search and learn. Read and write may be aimed at the data array, the mask array, the device registers or an external SRAM, and that target is carried in the parameter bits. The block only captures and classifies commands. It does not execute them.

When a command is malformed, the block drops it and raises a one-cycle protocol-error pulse, or it quietly discards the partial command, depending on the fault.

Top module: `cmd_capture_top`

## Requirements
- R1: The opcode is `cmdBus[1:0]`: 00 read, 01 write, 10 search, 11 learn. With each valid pulse, `opHot` has exactly one bit set, at the index equal to the opcode (bit0 read, bit1 write, bit2 search, bit3 learn).
- R2: A first cycle is a clock edge with `cmdValid` high and `phaseN` low. A second cycle is the next edge with `cmdValid` high and `phaseN` high.
- R3: The command word is `{opcode[15:14], paramSecond[13:7], paramFirst[6:0]}`, where each param is `cmdBus[8:2]` of its cycle.
- R4: `outValid` is high for exactly one cycle. That is the cycle after the second-cycle edge, because the outputs are registered at that edge.
- R5: If the second-cycle opcode differs from the first-cycle opcode, the block raises no `outValid`. Instead `protoErr` pulses for one cycle with the same timing.
- R6: If `cmdValid` is low on the edge after a first cycle, the partial command is discarded without a pulse or error. A later second-phase cycle then produces nothing.
- R7: A first cycle that arrives while a first half is held replaces the held half, and the new command proceeds normally.
- R8: An edge with `cmdValid` high and `phaseN` high while no first half is held is ignored.
- R9: A new first cycle may follow a second cycle directly, which gives back-to-back commands every two cycles.
- R10: Synchronous reset clears the capture state, `outWord`, `opHot`, `outValid` and `protoErr`. Between pulses `outWord` holds its last value.
- R11: `opHot` is all zero whenever `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command bus qualifier |
| phaseN | input | 1 | Low marks the first cycle of a command |
| cmdBus | input | 9 | Opcode [1:0] and parameters [8:2] |
| outValid | output | 1 | One-cycle pulse, command word valid |
| protoErr | output | 1 | One-cycle pulse, opcode mismatch |
| outWord | output | 16 | Captured command word |
| opHot | output | 4 | One-hot operation decode |

## Verification
Every result (`outValid`, `protoErr`, `outWord` and `opHot`) is due exactly one edge after the second-cycle edge. An aborted or ignored cycle changes nothing at that same edge. The bench drives inputs on the falling edge and steps its reference model at the rising edge. It compares all four outputs at the next falling edge, before it drives anything new. That way each edge's result is checked in the one cycle where it is due. Directed sequences cover aborts, restarts, stray second halves, mismatches and back-to-back commands. Seeded random command streams then mix all of these.

// File: rtl/cmd_capture_pkg.sv
package cmd_capture_pkg;
  localparam int CMD_W_DEF = 9;
  localparam int OP_W_DEF  = 2;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_SEARCH = 2'b10,
    OP_LEARN  = 2'b11
  } opcode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_HAVE_A = 1'b1
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;
    logic emit;
    logic flagErr;
  } capStrobe_t;
endpackage

// File: rtl/cmd_capture_ctrl.sv
module cmd_capture_ctrl
  import cmd_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic       phaseN,
  input  logic       opMatch,
  output capStrobe_t strobe
);
  capState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && !phaseN) begin
          strobe.loadFirst = 1'b1;
          stateNext        = ST_HAVE_A;
        end
      end
      ST_HAVE_A: begin
        if (!cmdValid) begin
          stateNext = ST_IDLE;
        end else if (!phaseN) begin
          strobe.loadFirst = 1'b1;
          stateNext        = ST_HAVE_A;
        end else begin
          if (opMatch) strobe.emit    = 1'b1;
          else         strobe.flagErr = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end
endmodule

// File: rtl/cmd_capture_dp.sv
module cmd_capture_dp
  import cmd_capture_pkg::*;
#(
  parameter int CMD_W = CMD_W_DEF,
  parameter int OP_W  = OP_W_DEF,
  localparam int PAR_W  = CMD_W - OP_W,
  localparam int WORD_W = OP_W + 2 * PAR_W,
  localparam int N_OPS  = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmdBus,
  input  capStrobe_t        strobe,
  output logic              opMatch,
  output logic              outValid,
  output logic              protoErr,
  output logic [WORD_W-1:0] outWord,
  output logic [N_OPS-1:0]  opHot
);
  logic [OP_W-1:0]  opFirst;
  logic [PAR_W-1:0] parFirst;
  logic [N_OPS-1:0] opDecode;

  assign opMatch = (cmdBus[OP_W-1:0] == opFirst);

  for (genvar i = 0; i < N_OPS; i++) begin : g_dec
    assign opDecode[i] = (opFirst == OP_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opFirst  <= '0;
      parFirst <= '0;
    end else if (strobe.loadFirst) begin
      opFirst  <= cmdBus[OP_W-1:0];
      parFirst <= cmdBus[CMD_W-1:OP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      protoErr <= 1'b0;
      outWord  <= '0;
      opHot    <= '0;
    end else begin
      outValid <= strobe.emit;
      protoErr <= strobe.flagErr;
      opHot    <= strobe.emit ? opDecode : '0;
      if (strobe.emit)
        outWord <= {opFirst, cmdBus[CMD_W-1:OP_W], parFirst};
    end
  end
endmodule

// File: rtl/cmd_capture_top.sv
module cmd_capture_top
  import cmd_capture_pkg::*;
#(
  parameter int CMD_W = CMD_W_DEF,
  parameter int OP_W  = OP_W_DEF,
  localparam int PAR_W  = CMD_W - OP_W,
  localparam int WORD_W = OP_W + 2 * PAR_W,
  localparam int N_OPS  = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic              phaseN,
  input  logic [CMD_W-1:0]  cmdBus,
  output logic              outValid,
  output logic              protoErr,
  output logic [WORD_W-1:0] outWord,
  output logic [N_OPS-1:0]  opHot
);
  capStrobe_t strobe;
  logic       opMatch;

  cmd_capture_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .phaseN   (phaseN),
    .opMatch  (opMatch),
    .strobe   (strobe)
  );

  cmd_capture_dp #(.CMD_W(CMD_W), .OP_W(OP_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .cmdBus   (cmdBus),
    .strobe   (strobe),
    .opMatch  (opMatch),
    .outValid (outValid),
    .protoErr (protoErr),
    .outWord  (outWord),
    .opHot    (opHot)
  );
endmodule

// File: rtl/cmd_capture_chk.sv
module cmd_capture_chk #(
  parameter int CMD_W = 9,
  parameter int OP_W  = 2,
  localparam int PAR_W  = CMD_W - OP_W,
  localparam int WORD_W = OP_W + 2 * PAR_W,
  localparam int N_OPS  = 1 << OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              phaseN,
  input logic [CMD_W-1:0]  cmdBus,
  input logic              outValid,
  input logic              protoErr,
  input logic [WORD_W-1:0] outWord,
  input logic [N_OPS-1:0]  opHot
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($countones(opHot) == 1 && opHot[outWord[WORD_W-1 -: OP_W]]));

  p_pair_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(cmdValid) && $past(phaseN) && $past(cmdValid, 2) && !$past(phaseN, 2)));

  p_layout_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outWord[WORD_W-1 -: OP_W] == $past(cmdBus[OP_W-1:0])
               && outWord[2*PAR_W-1 -: PAR_W] == $past(cmdBus[CMD_W-1:OP_W])
               && outWord[PAR_W-1:0] == $past(cmdBus[CMD_W-1:OP_W], 2)));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  p_err_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(outValid && protoErr));

  p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> !protoErr);

  p_hold_word_r10: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outWord) || $past(rst));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!outValid && !protoErr && outWord == '0 && opHot == '0));

  p_idle_hot_r11: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (opHot == '0));
endmodule

bind cmd_capture_top cmd_capture_chk #(.CMD_W(CMD_W), .OP_W(OP_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cmdValid (cmdValid),
  .phaseN   (phaseN),
  .cmdBus   (cmdBus),
  .outValid (outValid),
  .protoErr (protoErr),
  .outWord  (outWord),
  .opHot    (opHot)
);

// File: tb/test_cmd_capture_top.sv
`timescale 1ns/1ps
module test_cmd_capture_top;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_W = 9;
  localparam int OP_W  = 2;
  localparam int PAR_W = CMD_W - OP_W;
  localparam int WORD_W = OP_W + 2 * PAR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic phaseN = 1'b1;
  logic [CMD_W-1:0] cmdBus = '0;
  logic outValid, protoErr;
  logic [WORD_W-1:0] outWord;
  logic [3:0] opHot;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  // reference model state
  bit mHave = 0;
  logic [OP_W-1:0] mOp = '0;
  logic [PAR_W-1:0] mPar = '0;
  logic eValid = 0, eErr = 0;
  logic [WORD_W-1:0] eWord = '0;
  logic [3:0] eHot = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_capture_top i_cmd_capture_top (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .phaseN(phaseN), .cmdBus(cmdBus),
    .outValid(outValid), .protoErr(protoErr), .outWord(outWord), .opHot(opHot)
  );

  function automatic logic [3:0] hotOf(input logic [1:0] op);
    return 4'b0001 << op;
  endfunction

  function automatic logic [CMD_W-1:0] mkBus(input logic [1:0] op, input logic [PAR_W-1:0] par);
    return {par, op};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic r, input logic v, input logic ph, input logic [CMD_W-1:0] bus);
    rst = r; cmdValid = v; phaseN = ph; cmdBus = bus;
    @(posedge clk);
    eValid = 0; eErr = 0; eHot = '0;
    if (r) begin
      mHave = 0; eWord = '0; mOp = '0; mPar = '0;
    end else if (!mHave) begin
      if (v && !ph) begin mHave = 1; mOp = bus[1:0]; mPar = bus[CMD_W-1:OP_W]; end
    end else begin
      if (!v) mHave = 0;
      else if (!ph) begin mOp = bus[1:0]; mPar = bus[CMD_W-1:OP_W]; end
      else begin
        mHave = 0;
        if (bus[1:0] == mOp) begin
          eValid = 1; eHot = hotOf(mOp);
          eWord = {mOp, bus[CMD_W-1:OP_W], mPar};
        end else eErr = 1;
      end
    end
    @(negedge clk);
    check(tag, "outValid(R4)", outValid, eValid);
    check(tag, "protoErr(R5)", protoErr, eErr);
    check(tag, "outWord(R3)", outWord, eWord);
    check(tag, "opHot(R1/R11)", opHot, eHot);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 1, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step("R10 reset", 1, 0, 1, '0);
    step("R10 reset", 1, 1, 0, mkBus(2'b11, 7'h7f));
    idle("R10 idle", 2);

    // R1/R3/R4: each opcode as a well-formed pair
    for (int op = 0; op < 4; op++) begin
      step("R2 first", 0, 1, 0, mkBus(op[1:0], 7'h15 + 7'(op)));
      step("R4 second", 0, 1, 1, mkBus(op[1:0], 7'h6a - 7'(op)));
      idle("R10 hold", 1);
    end
    // R5 mismatch
    step("R5 first", 0, 1, 0, mkBus(2'b01, 7'h33));
    step("R5 mismatch", 0, 1, 1, mkBus(2'b10, 7'h44));
    idle("R5 after", 1);
    // R6 abort then stray second half
    step("R6 first", 0, 1, 0, mkBus(2'b10, 7'h11));
    step("R6 abort", 0, 0, 1, mkBus(2'b10, 7'h22));
    step("R6 stray", 0, 1, 1, mkBus(2'b10, 7'h22));
    // R8 stray second half while idle
    step("R8 stray", 0, 1, 1, mkBus(2'b00, 7'h55));
    step("R8 stray", 0, 1, 1, mkBus(2'b00, 7'h56));
    // R7 restart
    step("R7 first", 0, 1, 0, mkBus(2'b00, 7'h01));
    step("R7 restart", 0, 1, 0, mkBus(2'b11, 7'h02));
    step("R7 second", 0, 1, 1, mkBus(2'b11, 7'h03));
    // R9 back-to-back
    for (int k = 0; k < 3; k++) begin
      step("R9 first", 0, 1, 0, mkBus(2'(k), 7'(k * 9 + 4)));
      step("R9 second", 0, 1, 1, mkBus(2'(k), 7'(k * 5 + 1)));
    end
    // R10 reset mid-command
    step("R10 first", 0, 1, 0, mkBus(2'b01, 7'h0f));
    step("R10 reset", 1, 1, 1, mkBus(2'b01, 7'h0f));
    step("R10 after", 0, 1, 1, mkBus(2'b01, 7'h0f));

    // random command streams
    for (int it = 0; it < 1500; it++) begin
      int kind = $urandom_range(0, 9);
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [1:0] op2 = 2'($urandom_range(0, 3));
      if (kind < 5) begin
        step("R4 rand", 0, 1, 0, mkBus(op, 7'($urandom)));
        step("R4 rand", 0, 1, 1, mkBus(op, 7'($urandom)));
      end else if (kind < 7) begin
        step("R5 rand", 0, 1, 0, mkBus(op, 7'($urandom)));
        step("R5 rand", 0, 1, 1, mkBus(op2, 7'($urandom)));
      end else begin
        step("R8 rand", 0, 1'($urandom), 1'($urandom), 9'($urandom));
      end
    end
    idle("R11 end", 2);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      testCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule